// File: doc/BRIEF.md
# Serial EEPROM Command Front End

This block is the slave side of a four-wire serial memory. It takes a chip select, a serial clock, serial input data and a write-protect pin, and it drives serial output data with an enable for the pad. It holds a 512-byte array of registers that stands in for the nonvolatile cells. The design first decodes an instruction byte. It then serves byte reads that run on through the address space, single-byte writes, a write-enable latch, and a status register. That register holds the protection level and the two watchdog bits. The watchdog bits go out on a port for a separate watchdog block.

All pins are sampled by the system clock through two-flop synchronizers. The serial clock must therefore run well below the system clock. A write is committed when chip select returns high after a whole data byte. A down-counter then models the internal programming time. While it runs the part reports busy and refuses further writes. Writes into the locked fraction of the array are dropped quietly. Those locations can still be read.

Top module: `eeprom_spi_ctrl`

## Requirements
- R1: The block samples serial input on each rising serial clock edge, most significant bit first. The first bit is taken on the first rising edge after chip select goes low. Chip select high returns the decoder to the start of an instruction.
- R2: Opcode 0x03, with address bit 8 placed in opcode bit 3, followed by a byte holding address bits 7..0, reads the array. Data leaves on falling serial clock edges, MSB first. The address steps by one per byte and wraps from 0x1FF to 0x000 while chip select stays low.
- R3: Opcode 0x02, with address bit 8 in bit 3, plus an address byte and a data byte, stores that byte when chip select rises. Nothing is stored if chip select rises before all eight data bits have arrived.
- R4: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. A write or a status write issued while the latch is clear changes nothing and starts no busy period.
- R5: The write-enable latch is clear after reset. It clears when a write or status-write busy period ends, and it stays clear while the write-protect pin is low.
- R6: Opcode 0x05 returns the status byte and repeats it for every further byte. Bit 0 is busy, bit 1 the latch, bits 3:2 the protection level, bits 5:4 the watchdog bits, and bits 7:6 read 0. While busy the whole byte reads 0xFF.
- R7: An accepted write or status write sets busy for WRITE_CYCLES system clocks.
- R8: Protection level 0 locks nothing, 1 locks 0x180–0x1FF, 2 locks 0x100–0x1FF and 3 locks the whole array. A write to a locked address leaves the data unchanged, leaves the latch set and starts no busy period.
- R9: Opcode 0x01 with one data byte, accepted on chip select rise, loads the protection level from bits 3:2 and the watchdog bits from bits 5:4. Both are 0 after reset and change by no other means.
- R10: A write or a status write issued while busy is ignored.
- R11: The serial output enable is low while chip select is high. The watchdog output always carries status bits 5:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| wpN | input | 1 | Write protect, active low |
| so | output | 1 | Serial data out |
| soOe | output | 1 | Output enable for the serial data pad |
| wdBits | output | 2 | Watchdog setting bits for the watchdog block |

## Verification
The assertions assume that every serial clock phase lasts several system clocks. Synchronized edges are then never lost or merged, and chip select and data settle before the next sampled edge. The bench holds each serial clock half period at six system clocks. It changes serial input only in the low phase and keeps chip select steady for several clocks around each transfer. After any write attempt it waits longer than the programming time, unless it is testing busy behaviour on purpose. Random operations keep the write-protect pin high, so the protected-pin case is covered only by its directed test.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam logic [7:0] OP_SET_WEL = 8'h06;
  localparam logic [7:0] OP_CLR_WEL = 8'h04;
  localparam logic [7:0] OP_RD_STAT = 8'h05;
  localparam logic [7:0] OP_WR_STAT = 8'h01;
  localparam logic [7:0] OP_READ    = 8'h03;
  localparam logic [7:0] OP_WRITE   = 8'h02;
  localparam int         ADDR_W     = 9;

  typedef struct packed {
    logic              setWel;
    logic              clrWel;
    logic              wrByte;
    logic              wrStat;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        data;
  } ctrlStrb_t;
endpackage

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              si,
  input  logic              wpN,
  input  logic [7:0]        rdData,
  input  logic [7:0]        statusByte,
  output ctrlStrb_t         strb,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              wpSyncN,
  output logic              so,
  output logic              soOe
);
  typedef enum logic [2:0] {S_CMD, S_ADDR, S_RDATA, S_STAT, S_WDATA, S_WSTAT, S_DONE} state_t;

  logic [2:0] sckS;
  logic [2:0] csS;
  logic [1:0] siS;
  logic [1:0] wpS;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckS <= '0;
      csS  <= '1;
      siS  <= '0;
      wpS  <= '0;
    end else begin
      sckS <= {sckS[1:0], sck};
      csS  <= {csS[1:0], csN};
      siS  <= {siS[0], si};
      wpS  <= {wpS[0], wpN};
    end
  end

  logic csAct, csWasAct, sckRise, sckFall;
  assign csAct    = !csS[1];
  assign csWasAct = !csS[2];
  assign sckRise  = sckS[1] & !sckS[2];
  assign sckFall  = !sckS[1] & sckS[2];
  assign wpSyncN  = wpS[1];
  assign soOe     = csAct;

  state_t            state;
  logic [2:0]        bitCnt;
  logic [6:0]        shReg;
  logic [7:0]        outSh;
  logic [7:0]        dataReg;
  logic [ADDR_W-1:0] addrReg;
  logic              aHi, isRead, loadPend, pendWr, pendSt;
  logic              pSet, pClr, pWr, pSt;
  logic [7:0]        nb;

  assign nb     = {shReg, siS[1]};
  assign rdAddr = addrReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_CMD;
      bitCnt   <= '0;
      shReg    <= '0;
      outSh    <= '0;
      dataReg  <= '0;
      addrReg  <= '0;
      aHi      <= 1'b0;
      isRead   <= 1'b0;
      loadPend <= 1'b0;
      pendWr   <= 1'b0;
      pendSt   <= 1'b0;
      pSet     <= 1'b0;
      pClr     <= 1'b0;
      pWr      <= 1'b0;
      pSt      <= 1'b0;
      so       <= 1'b0;
    end else begin
      pSet <= 1'b0;
      pClr <= 1'b0;
      pWr  <= 1'b0;
      pSt  <= 1'b0;
      if (!csAct) begin
        state    <= S_CMD;
        bitCnt   <= '0;
        loadPend <= 1'b0;
        pendWr   <= 1'b0;
        pendSt   <= 1'b0;
        if (csWasAct) begin
          pWr <= pendWr;
          pSt <= pendSt;
        end
      end else begin
        if (loadPend) begin
          outSh    <= rdData;
          loadPend <= 1'b0;
        end
        if (sckRise) begin
          shReg  <= nb[6:0];
          bitCnt <= bitCnt + 3'd1;
          if (bitCnt == 3'd7) begin
            unique case (state)
              S_CMD: begin
                if (nb == OP_SET_WEL) begin
                  pSet  <= 1'b1;
                  state <= S_DONE;
                end else if (nb == OP_CLR_WEL) begin
                  pClr  <= 1'b1;
                  state <= S_DONE;
                end else if (nb == OP_RD_STAT) begin
                  outSh <= statusByte;
                  state <= S_STAT;
                end else if (nb == OP_WR_STAT) begin
                  state <= S_WSTAT;
                end else if ({nb[7:4], 1'b0, nb[2:0]} == OP_READ) begin
                  aHi    <= nb[3];
                  isRead <= 1'b1;
                  state  <= S_ADDR;
                end else if ({nb[7:4], 1'b0, nb[2:0]} == OP_WRITE) begin
                  aHi    <= nb[3];
                  isRead <= 1'b0;
                  state  <= S_ADDR;
                end else begin
                  state <= S_DONE;
                end
              end
              S_ADDR: begin
                addrReg <= {aHi, nb};
                if (isRead) begin
                  loadPend <= 1'b1;
                  state    <= S_RDATA;
                end else begin
                  state <= S_WDATA;
                end
              end
              S_RDATA: begin
                addrReg  <= addrReg + 1'b1;
                loadPend <= 1'b1;
              end
              S_STAT: outSh <= statusByte;
              S_WDATA: begin
                dataReg <= nb;
                pendWr  <= 1'b1;
                state   <= S_DONE;
              end
              S_WSTAT: begin
                dataReg <= nb;
                pendSt  <= 1'b1;
                state   <= S_DONE;
              end
              default: state <= S_DONE;
            endcase
          end
        end
        if (sckFall) begin
          so    <= outSh[7];
          outSh <= {outSh[6:0], 1'b0};
        end
      end
    end
  end

  assign strb = '{setWel: pSet, clrWel: pClr, wrByte: pWr, wrStat: pSt,
                  addr: addrReg, data: dataReg};

  // R1
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csAct |=> (state == S_CMD && bitCnt == 3'd0));
  // R3
  commit_on_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pWr || pSt) |-> !csAct);
endmodule

// File: rtl/eeprom_datapath.sv
module eeprom_datapath
  import eeprom_pkg::*;
#(
  parameter int WRITE_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              wpSyncN,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic [7:0]        statusByte,
  output logic [1:0]        wdBits
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [1:0]       blReg, wdReg;
  logic             wel, busy, hit, wrOk, stOk;

  always_comb begin
    unique case (blReg)
      2'd0: hit = 1'b0;
      2'd1: hit = (strb.addr[ADDR_W-1:ADDR_W-2] == 2'b11);
      2'd2: hit = strb.addr[ADDR_W-1];
      default: hit = 1'b1;
    endcase
  end

  assign busy = (cnt != '0);
  assign wrOk = strb.wrByte && !busy && wel && wpSyncN && !hit;
  assign stOk = strb.wrStat && !busy && wel && wpSyncN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wrOk) begin
      mem[strb.addr] <= strb.data;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      blReg <= '0;
      wdReg <= '0;
      wel   <= 1'b0;
    end else begin
      if (wrOk || stOk) cnt <= CNT_W'(WRITE_CYCLES);
      else if (busy)    cnt <= cnt - 1'b1;
      if (stOk) begin
        blReg <= strb.data[3:2];
        wdReg <= strb.data[5:4];
      end
      if (!wpSyncN)                    wel <= 1'b0;
      else if (busy && cnt == CNT_W'(1)) wel <= 1'b0;
      else if (strb.setWel)            wel <= 1'b1;
      else if (strb.clrWel)            wel <= 1'b0;
    end
  end

  assign rdData     = mem[rdAddr];
  assign statusByte = busy ? 8'hFF : {2'b00, wdReg, blReg, wel, 1'b0};
  assign wdBits     = wdReg;

  // R5
  wel_wp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wpSyncN |=> !wel);
  // R5
  wel_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !wel);
  // R4
  wr_needs_wel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wel));
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (strb.wrByte || strb.wrStat)) |=> ($stable(blReg) && $stable(wdReg)));
  // R9
  bl_only_wrsr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (blReg != $past(blReg)) |-> $past(strb.wrStat));
  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt > CNT_W'(1)) |=> busy);
endmodule

// File: rtl/eeprom_spi_ctrl.sv
module eeprom_spi_ctrl
  import eeprom_pkg::*;
#(
  parameter int WRITE_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sck,
  input  logic       si,
  input  logic       wpN,
  output logic       so,
  output logic       soOe,
  output logic [1:0] wdBits
);
  ctrlStrb_t         strb;
  logic [ADDR_W-1:0] rdAddr;
  logic [7:0]        rdData, statusByte;
  logic              wpSyncN;

  eeprom_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .wpN(wpN),
    .rdData(rdData), .statusByte(statusByte), .strb(strb), .rdAddr(rdAddr),
    .wpSyncN(wpSyncN), .so(so), .soOe(soOe)
  );

  eeprom_datapath #(.WRITE_CYCLES(WRITE_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wpSyncN(wpSyncN), .rdAddr(rdAddr),
    .rdData(rdData), .statusByte(statusByte), .wdBits(wdBits)
  );
endmodule

// File: tb/sim_eeprom_spi_ctrl.sv
module sim_eeprom_spi_ctrl;
  localparam int WC   = 600;
  localparam int HALF = 6;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sck = 1'b0, si = 1'b0, wpN = 1'b1;
  logic so, soOe;
  logic [1:0] wdBits;
  always #2.5 clk = ~clk;

  eeprom_spi_ctrl #(.WRITE_CYCLES(WC)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .wpN(wpN),
    .so(so), .soOe(soOe), .wdBits(wdBits)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] m [512];
  logic mWel = 1'b0;
  logic [1:0] mBl = 2'd0, mWd = 2'd0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit prot(input logic [1:0] bl, input logic [8:0] a);
    case (bl)
      2'd0: return 1'b0;
      2'd1: return a >= 9'h180;
      2'd2: return a >= 9'h100;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] expStat();
    return {2'b00, mWd, mBl, mWel, 1'b0};
  endfunction

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < n; i++) begin
      si = tx[7-i];
      w(HALF);
      rx[7-i] = so;
      sck = 1'b1;
      w(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic csOn();  csN = 1'b0; w(4); endtask
  task automatic csOff(); w(4); csN = 1'b1; w(6); endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    csOn(); bits(op, 8, d); csOff();
  endtask

  task automatic rdStat(output logic [7:0] s);
    logic [7:0] d;
    csOn(); bits(8'h05, 8, d); bits(8'h00, 8, s); csOff();
  endtask

  task automatic wrByte(input logic [8:0] a, input logic [7:0] v);
    logic [7:0] d;
    csOn(); bits(8'h02 | {4'd0, a[8], 3'd0}, 8, d); bits(a[7:0], 8, d); bits(v, 8, d); csOff();
  endtask

  task automatic wrStat(input logic [7:0] v);
    logic [7:0] d;
    csOn(); bits(8'h01, 8, d); bits(v, 8, d); csOff();
  endtask

  // model update for a write attempt while not busy
  task automatic modelWrite(input logic [8:0] a, input logic [7:0] v);
    if (mWel && !prot(mBl, a)) begin
      m[a] = v;
      mWel = 1'b0;
    end
  endtask

  task automatic readChk(input string req, input logic [8:0] a, input int n);
    logic [7:0] d;
    logic [8:0] p;
    p = a;
    csOn(); bits(8'h03 | {4'd0, a[8], 3'd0}, 8, d); bits(a[7:0], 8, d);
    for (int i = 0; i < n; i++) begin
      bits(8'h00, 8, d);
      chk(req, {23'd0, p, d}, {23'd0, p, m[p]});
      p = p + 9'd1;
    end
    csOff();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d;
    int unsigned seed;
    for (int i = 0; i < 512; i++) m[i] = 8'h00;
    seed = $urandom(32'hC0FFEE);
    w(5);
    rstN = 1'b1;
    w(5);
    // R11 reset state of the pad enable and watchdog bits
    chk("R11 soOe idle", {31'd0, soOe}, 32'd0);
    chk("R11 wdBits reset", {30'd0, wdBits}, 32'd0);
    rdStat(s); chk("R6 status after reset", {24'd0, s}, 32'h00);
    // R4 latch set and clear
    cmd1(8'h06); rdStat(s); chk("R4 set latch", {24'd0, s}, 32'h02);
    cmd1(8'h04); rdStat(s); chk("R4 clear latch", {24'd0, s}, 32'h00);
    wrByte(9'h055, 8'hA5); w(WC + 100);
    rdStat(s); chk("R4 no busy without latch", {24'd0, s}, 32'h00);
    readChk("R4 write without latch", 9'h055, 1);
    // R3 R6 R7 R5 accepted write, busy reads 0xFF then clears with latch
    cmd1(8'h06); mWel = 1'b1;
    wrByte(9'h1FF, 8'h3C); modelWrite(9'h1FF, 8'h3C);
    rdStat(s); chk("R6 R7 busy status", {24'd0, s}, 32'hFF);
    w(WC + 100);
    rdStat(s); chk("R5 R7 latch cleared after cycle", {24'd0, s}, 32'h00);
    cmd1(8'h06); mWel = 1'b1;
    wrByte(9'h000, 8'h11); modelWrite(9'h000, 8'h11); w(WC + 100);
    cmd1(8'h06); mWel = 1'b1;
    wrByte(9'h100, 8'h77); modelWrite(9'h100, 8'h77); w(WC + 100);
    readChk("R2 wrap 1FF to 000", 9'h1FF, 3);
    readChk("R2 A8 in opcode", 9'h100, 1);
    readChk("R3 low half kept", 9'h000, 1);
    // R3 partial data byte is dropped
    cmd1(8'h06); mWel = 1'b1;
    csOn(); bits(8'h02, 8, d); bits(8'h40, 8, d); bits(8'hF0, 4, d); csOff();
    w(WC + 100);
    readChk("R3 partial byte", 9'h040, 1);
    rdStat(s); chk("R3 partial keeps latch", {24'd0, s}, {24'd0, expStat()});
    // R5 write-protect pin clears latch
    wpN = 1'b0; w(10);
    rdStat(s); mWel = 1'b0; chk("R5 wp low clears latch", {24'd0, s}, 32'h00);
    cmd1(8'h06);
    rdStat(s); chk("R5 latch held clear under wp", {24'd0, s}, 32'h00);
    wpN = 1'b1; w(10);
    // R9 status write, bits 7:6 ignored
    cmd1(8'h06); mWel = 1'b1;
    wrStat(8'hFF); mBl = 2'd3; mWd = 2'd3; mWel = 1'b0; w(WC + 100);
    rdStat(s); chk("R9 status write", {24'd0, s}, 32'h3C);
    chk("R11 wdBits follows status", {30'd0, wdBits}, 32'd3);
    // R8 protection levels
    cmd1(8'h06); mWel = 1'b1;
    wrByte(9'h010, 8'h99); modelWrite(9'h010, 8'h99); w(20);
    rdStat(s); chk("R8 locked write no busy latch kept", {24'd0, s}, 32'h3E);
    readChk("R8 all locked", 9'h010, 1);
    wrStat(8'h04); mBl = 2'd1; mWd = 2'd0; mWel = 1'b0; w(WC + 100);
    cmd1(8'h06); mWel = 1'b1;
    wrByte(9'h180, 8'h5A); modelWrite(9'h180, 8'h5A); w(20);
    wrByte(9'h17F, 8'h6B); modelWrite(9'h17F, 8'h6B); w(WC + 100);
    readChk("R8 level1 boundary", 9'h17F, 2);
    cmd1(8'h06); mWel = 1'b1;
    wrStat(8'h08); mBl = 2'd2; mWel = 1'b0; w(WC + 100);
    cmd1(8'h06); mWel = 1'b1;
    wrByte(9'h100, 8'hC3); modelWrite(9'h100, 8'hC3); w(20);
    wrByte(9'h0FF, 8'hD4); modelWrite(9'h0FF, 8'hD4); w(WC + 100);
    readChk("R8 level2 boundary", 9'h0FF, 2);
    cmd1(8'h06); mWel = 1'b1;
    wrStat(8'h00); mBl = 2'd0; mWel = 1'b0; w(WC + 100);
    // R10 write while busy ignored
    cmd1(8'h06); mWel = 1'b1;
    wrByte(9'h020, 8'hAA); modelWrite(9'h020, 8'hAA);
    cmd1(8'h06);
    wrByte(9'h021, 8'hBB);
    wrStat(8'h0C);
    w(WC + 100);
    readChk("R10 write during busy", 9'h020, 2);
    rdStat(s); chk("R10 status write during busy", {24'd0, s}, 32'h00);
    // R1 random mix against model
    for (int it = 0; it < 40; it++) begin
      int op;
      logic [8:0] a;
      logic [7:0] v;
      op = int'($urandom % 6);
      a  = 9'($urandom);
      v  = 8'($urandom);
      case (op)
        0, 1: begin
          cmd1(8'h06); mWel = 1'b1;
          wrByte(a, v); modelWrite(a, v); w(WC + 100);
        end
        2: readChk("R1 R2 random read", a, 3);
        3: begin
          cmd1(8'h06); mWel = 1'b1;
          v[3] = v[3] & v[7];
          wrStat(v); mBl = v[3:2]; mWd = v[5:4]; mWel = 1'b0; w(WC + 100);
        end
        4: begin cmd1(8'h04); mWel = 1'b0; end
        default: begin cmd1(8'h06); mWel = 1'b1; end
      endcase
      rdStat(s); chk("R1 R6 random status", {24'd0, s}, {24'd0, expStat()});
      chk("R11 random wdBits", {30'd0, wdBits}, {30'd0, mWd});
    end
    if (seed == 32'hFFFF_FFFF) $display("seed edge");
    chk("R11 soOe after runs", {31'd0, soOe}, 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule